// File: doc/BRIEF.md
# Host-Firmware Circular Mailbox

The block links a host bus and an embedded firmware agent through two circular word buffers, one for each direction. Each side has its own small register port with four word addresses. One address is a window that pushes a word into the outgoing buffer. One is the side's own control/status word. One is a read-only view of the peer's control/status word. The last is a window that pops the head of the incoming buffer.

Occupancy is not reported as a count. Each status word carries the buffer depth, the write pointer and the read pointer, and software works out the fill level as the write pointer minus the read pointer, modulo 256. Each control word also holds an interrupt enable, a sticky interrupt status, a self-clearing doorbell, a ready flag and a sticky overflow flag. The host word adds a reset bit that clears both buffers and holds both sides out of the ready state.

A typical exchange runs like this. The sender writes its header and payload words into its write window, then rings its doorbell. The receiver's interrupt status rises. The receiver drains the words through its read window.

Top module: `mbx_mailbox`

## Requirements
- R1: Out of reset, every control/status word reads as its buffer depth in bits 31:24 and zero in all other bits. The host-to-firmware depth is 8 and the firmware-to-host depth is 4 by default. Both interrupt outputs are low.
- R2: A host write to address 0 pushes one word into the host-to-firmware buffer and raises the write pointer (bits 23:16 of host address 1) by one. A firmware read of address 3 returns the words in push order and raises the read pointer (bits 15:8) by one.
- R3: The firmware-to-host direction mirrors R2. Firmware pushes through its address 0, the host pops through its address 3, and the pointers of this buffer show at host address 2 and firmware address 1.
- R4: A push into a buffer that already holds depth words is dropped and leaves the write pointer unchanged. It sets the pusher's sticky overflow bit 5, which stays set until a 1 is written to bit 5.
- R5: A pop from an empty buffer returns zero and leaves both pointers unchanged.
- R6: Interrupt status (bit 1) is write-one-to-clear. Writing 0 to it leaves it unchanged.
- R7: Writing 1 to the doorbell (bit 2) makes it read 1 in the cycle after the write and 0 from the cycle after that. The write sets the peer's interrupt status.
- R8: When the ready bit (bit 3) of one side changes, the interrupt status of the other side is set.
- R9: Each interrupt output is high exactly when that side's interrupt status and interrupt enable (bit 0) are both 1.
- R10: While the host reset bit (bit 4) is 1, all four pointers are zero, pushes are ignored, and both ready bits read 0 and ignore writes. Writing 0 to bit 4 releases the reset.
- R11: When a peer event and a write-one-to-clear of the same interrupt status fall in the same cycle, the status ends up set.
- R12: A push and a pop on the same non-empty buffer in the same cycle both take effect, and the fill level is unchanged.
- R13: Pointers wrap from 255 to 0, and the buffer keeps word order across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_rd | input | 1 | Host read strobe; at address 3 it pops a word |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 2 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from h_addr |
| h_irq | output | 1 | Host interrupt |
| f_rd | input | 1 | Firmware read strobe; at address 3 it pops a word |
| f_wr | input | 1 | Firmware write strobe |
| f_addr | input | 2 | Firmware word address |
| f_wdata | input | 32 | Firmware write data |
| f_rdata | output | 32 | Firmware read data, combinational from f_addr |
| f_irq | output | 1 | Firmware interrupt |

## Verification
Two functions can fall in the same cycle: the setting of an interrupt status by the peer (its doorbell or a ready change) and the host clearing that same status by writing 1 to it. The bench provokes this by driving a firmware doorbell write and a host write-one-to-clear on the same clock edge. It then requires that the host status reads set and that the host interrupt output is high. A second pairing, a push and a pop on one buffer in the same cycle, is run for more than 256 cycles so that the pointers wrap, with the popped words compared against the pushed ones.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int MBX_W = 32;
   localparam int PTR_W = 8;
   localparam int CTL_W = 6;

   localparam logic [1:0] A_PUSH = 2'd0;
   localparam logic [1:0] A_OWN  = 2'd1;
   localparam logic [1:0] A_PEER = 2'd2;
   localparam logic [1:0] A_POP  = 2'd3;

   localparam int B_IE   = 0;
   localparam int B_IS   = 1;
   localparam int B_BELL = 2;
   localparam int B_RDY  = 3;
   localparam int B_RST  = 4;
   localparam int B_OVF  = 5;

   function automatic logic [MBX_W-1:0] pack_status(input logic [PTR_W-1:0] depth,
                                                    input logic [PTR_W-1:0] wp,
                                                    input logic [PTR_W-1:0] rp,
                                                    input logic [CTL_W-1:0] ctl);
      return {depth, wp, rp, 2'b00, ctl};
   endfunction
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring
   import mbx_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [PTR_W-1:0]  wptr,
   output logic [PTR_W-1:0]  rptr,
   output logic              drop
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mbx_ring: DEPTH must be a power of two from 1 to 128");
      end
   endgenerate

   logic [PTR_W-1:0]  wptr_q, rptr_q, fill;
   logic              full, empty, push_ok, pop_ok;
   logic [IDX_W-1:0]  widx, ridx;
   logic [DATA_W-1:0] words [DEPTH];

   assign fill    = wptr_q - rptr_q;
   assign full    = (fill == PTR_W'(DEPTH));
   assign empty   = (fill == '0);
   assign push_ok = push & ~full & ~clr;
   assign pop_ok  = pop & ~empty & ~clr;
   assign drop    = push & full & ~clr;

   generate
      if (DEPTH == 1) begin : g_idx_one
         assign widx = '0;
         assign ridx = '0;
      end else begin : g_idx_many
         assign widx = wptr_q[IDX_W-1:0];
         assign ridx = rptr_q[IDX_W-1:0];
      end
   endgenerate

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (push_ok && widx == IDX_W'(i))
               word_q <= push_data;
         end
         assign words[i] = word_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + 1'b1;
         if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      end
   end

   assign head = empty ? '0 : words[ridx];
   assign wptr = wptr_q;
   assign rptr = rptr_q;

   // R4
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= PTR_W'(DEPTH));
   // R4
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> $stable(wptr_q));
   // R5
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !clr) |=> $stable(rptr_q));
   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (wptr_q == '0 && rptr_q == '0));
endmodule

// File: rtl/mbx_csr.sv
module mbx_csr
   import mbx_pkg::*;
#(
   parameter bit HAS_RESET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             clr,
   input  logic             peer_evt,
   input  logic             ovf_evt,
   output logic [CTL_W-1:0] ctl,
   output logic             bell_evt,
   output logic             rdy_chg,
   output logic             rst_nx,
   output logic             irq
);
   logic ie_q, is_q, bell_q, rdy_q, ovf_q, rst_q;
   logic clr_eff, rdy_d;

   generate
      if (HAS_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= rst_nx;
         end
         assign rst_nx = wr ? wdata[B_RST] : rst_q;
      end else begin : g_no_rst
         logic unused_rst_bit;
         assign unused_rst_bit = wdata[B_RST];
         assign rst_q  = 1'b0;
         assign rst_nx = 1'b0;
      end
   endgenerate

   assign clr_eff  = clr | rst_nx;
   assign rdy_d    = clr_eff ? 1'b0 : (wr ? wdata[B_RDY] : rdy_q);
   assign rdy_chg  = (rdy_d != rdy_q);
   assign bell_evt = wr & wdata[B_BELL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         is_q   <= 1'b0;
         bell_q <= 1'b0;
         rdy_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (wr) ie_q <= wdata[B_IE];
         if (peer_evt)                is_q <= 1'b1;
         else if (wr && wdata[B_IS])  is_q <= 1'b0;
         bell_q <= bell_evt;
         rdy_q  <= rdy_d;
         if (clr_eff)                 ovf_q <= 1'b0;
         else if (ovf_evt)            ovf_q <= 1'b1;
         else if (wr && wdata[B_OVF]) ovf_q <= 1'b0;
      end
   end

   assign ctl = {ovf_q, rst_q, rdy_q, bell_q, is_q, ie_q};
   assign irq = ie_q & is_q;

   // R6
   is_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_q && !(wr && wdata[B_IS])) |=> is_q);
   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      peer_evt |=> is_q);
   // R10
   rdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_eff |=> !rdy_q);
   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_eff && !(wr && wdata[B_OVF])) |=> ovf_q);
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
   import mbx_pkg::*;
#(
   parameter int H2F_DEPTH = 8,
   parameter int F2H_DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h_rd,
   input  logic             h_wr,
   input  logic [1:0]       h_addr,
   input  logic [MBX_W-1:0] h_wdata,
   output logic [MBX_W-1:0] h_rdata,
   output logic             h_irq,
   input  logic             f_rd,
   input  logic             f_wr,
   input  logic [1:0]       f_addr,
   input  logic [MBX_W-1:0] f_wdata,
   output logic [MBX_W-1:0] f_rdata,
   output logic             f_irq
);
   localparam logic [PTR_W-1:0] H2F_D = PTR_W'(H2F_DEPTH);
   localparam logic [PTR_W-1:0] F2H_D = PTR_W'(F2H_DEPTH);

   logic [MBX_W-1:0] h2f_head, f2h_head;
   logic [PTR_W-1:0] h2f_wp, h2f_rp, f2h_wp, f2h_rp;
   logic             h2f_drop, f2h_drop;
   logic [CTL_W-1:0] h_ctl, f_ctl;
   logic             h_bell, h_rchg, h_rst_nx, f_bell, f_rchg, f_rst_nx;
   logic             h_csr_wr, f_csr_wr;
   logic [MBX_W-1:0] h_own, f_own;

   assign h_csr_wr = h_wr && h_addr == A_OWN;
   assign f_csr_wr = f_wr && f_addr == A_OWN;

   mbx_ring #(.DEPTH(H2F_DEPTH), .DATA_W(MBX_W)) u_h2f (
      .clk(clk), .rst_n(rst_n), .clr(h_rst_nx),
      .push(h_wr && h_addr == A_PUSH), .push_data(h_wdata),
      .pop(f_rd && f_addr == A_POP), .head(h2f_head),
      .wptr(h2f_wp), .rptr(h2f_rp), .drop(h2f_drop));

   mbx_ring #(.DEPTH(F2H_DEPTH), .DATA_W(MBX_W)) u_f2h (
      .clk(clk), .rst_n(rst_n), .clr(h_rst_nx),
      .push(f_wr && f_addr == A_PUSH), .push_data(f_wdata),
      .pop(h_rd && h_addr == A_POP), .head(f2h_head),
      .wptr(f2h_wp), .rptr(f2h_rp), .drop(f2h_drop));

   mbx_csr #(.HAS_RESET(1'b1)) u_hcsr (
      .clk(clk), .rst_n(rst_n), .wr(h_csr_wr), .wdata(h_wdata[CTL_W-1:0]),
      .clr(1'b0), .peer_evt(f_bell | f_rchg), .ovf_evt(h2f_drop),
      .ctl(h_ctl), .bell_evt(h_bell), .rdy_chg(h_rchg), .rst_nx(h_rst_nx),
      .irq(h_irq));

   mbx_csr #(.HAS_RESET(1'b0)) u_fcsr (
      .clk(clk), .rst_n(rst_n), .wr(f_csr_wr), .wdata(f_wdata[CTL_W-1:0]),
      .clr(h_rst_nx), .peer_evt(h_bell | h_rchg), .ovf_evt(f2h_drop),
      .ctl(f_ctl), .bell_evt(f_bell), .rdy_chg(f_rchg), .rst_nx(f_rst_nx),
      .irq(f_irq));

   logic unused_f_rst_nx;
   assign unused_f_rst_nx = f_rst_nx;

   assign h_own = pack_status(H2F_D, h2f_wp, h2f_rp, h_ctl);
   assign f_own = pack_status(F2H_D, f2h_wp, f2h_rp, f_ctl);

   always_comb begin
      unique case (h_addr)
         A_OWN:   h_rdata = h_own;
         A_PEER:  h_rdata = f_own;
         A_POP:   h_rdata = f2h_head;
         default: h_rdata = '0;
      endcase
      unique case (f_addr)
         A_OWN:   f_rdata = f_own;
         A_PEER:  f_rdata = h_own;
         A_POP:   f_rdata = h2f_head;
         default: f_rdata = '0;
      endcase
   end

   // R7
   bell_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_csr_wr && h_wdata[B_BELL]) |=> f_ctl[B_IS]);
   // R7
   bell_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f_csr_wr && f_wdata[B_BELL]) |=> h_ctl[B_IS]);
endmodule

// File: tb/mbx_mailbox_tb.sv
module mbx_mailbox_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_rd = 0, h_wr = 0, f_rd = 0, f_wr = 0;
   logic [1:0]  h_addr = 0, f_addr = 0;
   logic [31:0] h_wdata = 0, f_wdata = 0;
   logic [31:0] h_rdata, f_rdata;
   logic        h_irq, f_irq;
   int          checks = 0, failures = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   mbx_mailbox u_dut (
      .clk(clk), .rst_n(rst_n),
      .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
      .h_rdata(h_rdata), .h_irq(h_irq),
      .f_rd(f_rd), .f_wr(f_wr), .f_addr(f_addr), .f_wdata(f_wdata),
      .f_rdata(f_rdata), .f_irq(f_irq));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic h_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
      @(negedge clk); h_wr = 0;
   endtask
   task automatic f_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); f_addr = a; f_wdata = d; f_wr = 1;
      @(negedge clk); f_wr = 0;
   endtask
   task automatic h_pop(output logic [31:0] q);
      @(negedge clk); h_addr = 2'd3; h_rd = 1; #1 q = h_rdata;
      @(negedge clk); h_rd = 0;
   endtask
   task automatic f_pop(output logic [31:0] q);
      @(negedge clk); f_addr = 2'd3; f_rd = 1; #1 q = f_rdata;
      @(negedge clk); f_rd = 0;
   endtask
   task automatic h_peek(input logic [1:0] a, output logic [31:0] q);
      h_addr = a; #1 q = h_rdata;
   endtask
   task automatic f_peek(input logic [1:0] a, output logic [31:0] q);
      f_addr = a; #1 q = f_rdata;
   endtask

   task automatic t_reset_state();
      logic [31:0] q;
      h_peek(1, q); chk("R1 host own", q, 32'h0800_0000);
      h_peek(2, q); chk("R1 host peer", q, 32'h0400_0000);
      f_peek(1, q); chk("R1 fw own", q, 32'h0400_0000);
      f_peek(2, q); chk("R1 fw peer", q, 32'h0800_0000);
      chk("R1 irqs", {h_irq, f_irq}, 0);
   endtask

   task automatic t_h2f();
      logic [31:0] q;
      h_write(0, 32'hA0A0_0001); h_write(0, 32'hA0A0_0002); h_write(0, 32'hA0A0_0003);
      h_peek(1, q); chk("R2 wptr", q, 32'h0803_0000);
      f_pop(q); chk("R2 pop1", q, 32'hA0A0_0001);
      h_peek(1, q); chk("R2 rptr", q, 32'h0803_0100);
      f_pop(q); chk("R2 pop2", q, 32'hA0A0_0002);
      f_pop(q); chk("R2 pop3", q, 32'hA0A0_0003);
      f_pop(q); chk("R5 empty pop data", q, 0);
      f_peek(2, q); chk("R5 empty pop ptrs", q, 32'h0803_0300);
   endtask

   task automatic t_f2h();
      logic [31:0] q;
      f_write(0, 32'hB0B0_0001); f_write(0, 32'hB0B0_0002);
      h_peek(2, q); chk("R3 f2h ptrs", q, 32'h0402_0000);
      h_pop(q); chk("R3 pop1", q, 32'hB0B0_0001);
      h_pop(q); chk("R3 pop2", q, 32'hB0B0_0002);
      f_peek(1, q); chk("R3 fw own", q, 32'h0402_0200);
   endtask

   task automatic t_overflow();
      logic [31:0] q;
      int bad = 0;
      for (int i = 0; i < 9; i++) h_write(0, 32'hC000_0000 + i);
      h_peek(1, q); chk("R4 drop and flag", q, 32'h080B_0320);
      for (int i = 0; i < 8; i++) begin
         f_pop(q);
         if (q !== 32'hC000_0000 + i) bad++;
      end
      chk("R4 kept words", bad, 0);
      h_peek(1, q); chk("R4 flag sticky", q, 32'h080B_0B20);
      h_write(1, 32'h20);
      h_peek(1, q); chk("R4 flag cleared", q, 32'h080B_0B00);
   endtask

   task automatic t_bell_w1c();
      logic [31:0] q;
      f_write(1, 32'h04);
      f_peek(1, q); chk("R7 bell reads 1", q, 32'h0402_0204);
      h_peek(1, q); chk("R7 host status set", q, 32'h080B_0B02);
      chk("R9 irq masked", h_irq, 0);
      @(negedge clk); f_peek(1, q); chk("R7 bell self clear", q, 32'h0402_0200);
      h_write(1, 32'h01);
      h_peek(1, q); chk("R6 write 0 keeps", q, 32'h080B_0B03);
      chk("R9 irq high", h_irq, 1);
      h_write(1, 32'h03);
      h_peek(1, q); chk("R6 write 1 clears", q, 32'h080B_0B01);
      chk("R9 irq low", h_irq, 0);
      h_write(1, 32'h05);
      f_peek(1, q); chk("R7 fw status set", q[1], 1);
   endtask

   task automatic t_ready();
      logic [31:0] q;
      f_write(1, 32'h08);
      h_peek(1, q); chk("R8 ready change", q[1], 1);
      h_peek(2, q); chk("R8 fw ready seen", q[3], 1);
      h_write(1, 32'h03);
      h_peek(1, q); chk("R8 cleared", q, 32'h080B_0B01);
   endtask

   task automatic t_collide();
      logic [31:0] q;
      @(negedge clk);
      f_addr = 1; f_wdata = 32'h0C; f_wr = 1;
      h_addr = 1; h_wdata = 32'h03; h_wr = 1;
      @(negedge clk); f_wr = 0; h_wr = 0;
      h_peek(1, q); chk("R11 set wins", q, 32'h080B_0B03);
      chk("R11 irq", h_irq, 1);
      h_write(1, 32'h03);
   endtask

   task automatic t_stream();
      logic [31:0] q, exp;
      int bad = 0;
      h_write(0, 32'hD000_FFFF);
      exp = 32'hD000_FFFF;
      for (int k = 0; k < 260; k++) begin
         @(negedge clk);
         h_addr = 0; h_wdata = 32'hD000_0000 + k; h_wr = 1;
         f_addr = 3; f_rd = 1;
         #1 q = f_rdata;
         if (q !== exp) bad++;
         exp = 32'hD000_0000 + k;
      end
      @(negedge clk); h_wr = 0; f_rd = 0;
      chk("R12 stream order", bad, 0);
      h_peek(1, q); chk("R13 wrapped ptrs", q, 32'h0810_0F01);
      f_pop(q); chk("R13 last word", q, 32'hD000_0000 + 259);
   endtask

   task automatic t_reset_bit();
      logic [31:0] q;
      f_write(0, 32'hE000_0001);
      h_write(1, 32'h15);
      h_peek(1, q); chk("R10 enter", q, 32'h0800_0017);
      h_peek(2, q); chk("R10 fw view", q & 32'hFFFF_FF08, 32'h0400_0000);
      h_write(0, 32'h99); f_write(0, 32'h77); f_write(1, 32'h08);
      h_peek(1, q); chk("R10 push ignored", q & 32'hFFFF_FF00, 32'h0800_0000);
      h_peek(2, q); chk("R10 held", q & 32'hFFFF_FF08, 32'h0400_0000);
      h_write(1, 32'h04);
      h_peek(1, q); chk("R10 release", q[4], 0);
      f_write(1, 32'h08);
      h_peek(2, q); chk("R10 fw ready after", q[3], 1);
      h_write(1, 32'h0F);
      f_peek(2, q); chk("R10 host ready", q & 32'hFFFF_FF18, 32'h0800_0008);
      h_write(0, 32'h1234);
      h_peek(1, q); chk("R10 push resumes", q & 32'hFFFF_FF00, 32'h0801_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset_state();
      t_h2f();
      t_f2h();
      t_overflow();
      t_bell_w1c();
      t_ready();
      t_collide();
      t_stream();
      t_reset_bit();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule